// File: doc/BRIEF.md
# Fractional-N MASH Sigma-Delta Modulator

This block produces the division value that a fractional-N feedback divider uses on every reference clock. The divide value is an integer N plus a small signed correction. The correction comes from a cascade of up to four error-feedback accumulators. Each accumulator works modulo a programmable denominator DEN and is driven by a numerator NUM, so the long-run average of the divide value is N + NUM/DEN. The carries of the cascade are merged through a difference network, which pushes the quantisation noise to high offset frequencies. The order is selectable from integer-only up to fourth order.

The first accumulator starts from a programmable seed, which sets the phase of the output sequence. Two events start the accumulators again from this seed: the first clock edge after reset, and a phase-sync event. A phase-sync request arms a delay counter that counts state-machine ticks. The re-seed happens only once the programmed delay has run out, so several devices can restart the same sequence after their loops have settled.

Top module: `fracn_sdm`

## Requirements
- R1: Order codes 0, 5, 6 and 7 disable the modulator. While disabled, div_o equals n_int_i on every cycle and stages above the selected order keep their state.
- R2: While rst_ni is low, div_o equals n_int_i. At the first rising clock edge after release, stage 1 loads seed_i, the other stages load zero and the correction becomes zero. From the next edge on, the output follows that seeded state. Example: order 1, NUM=1, DEN=4, seed 3 gives N and then N+1.
- R3: On each active edge, every enabled stage forms acc+input. When that sum is at least DEN, the stage subtracts DEN and emits a carry of 1. The stage input is NUM for stage 1 and the new residue of the previous stage otherwise. With NUM<DEN and seed<DEN, every residue stays below DEN at the full 32-bit width.
- R4: For order k in 1..4, the registered correction equals c1 + (1-z^-1)c2 + (1-z^-1)^2 c3 + (1-z^-1)^3 c4, using only the first k carries. div_o = n_int_i + correction, and it changes once per clock edge.
- R5: At order 1, the corrections over any DEN consecutive cycles add up to exactly NUM.
- R6: At order k, the correction stays within -(2^(k-1)-1) .. 2^(k-1): that is 0..1, -1..2, -3..4 and -7..8 for orders 1 to 4.
- R7: A one-cycle sync_req_i sampled at an edge loads sync_dly_i into the delay counter and arms it. At each later edge where sm_tick_i is high, the counter decrements by one. The counter holds when sm_tick_i is low. At the first edge that finds the armed counter at zero, the block re-seeds exactly as in R2, so div_o equals n_int_i after that edge.
- R8: After a re-seed, the output sequence repeats the sequence that followed reset release, cycle for cycle.
- R9: A new sync request while the counter is armed restarts the count from the newly supplied delay.
- R10: A delay of zero re-seeds at the edge that directly follows the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| n_int_i | input | 19 | Integer part N of the division value |
| num_i | input | 32 | Fraction numerator NUM |
| den_i | input | 32 | Fraction denominator DEN (modulus) |
| seed_i | input | 32 | Start value of the first accumulator |
| order_i | input | 3 | Order select: 0 off, 1..4 order, 5..7 off |
| sm_tick_i | input | 1 | State-machine tick enable for the delay counter |
| sync_req_i | input | 1 | Phase-sync request, arms the re-seed delay |
| sync_dly_i | input | 32 | Re-seed delay in state-machine ticks |
| div_o | output | 20 | Instantaneous divide value N + correction |

## Verification
The residue and bound properties assume that DEN is non-zero, that NUM and the seed are below DEN, and that N is at least 8, so the 20-bit divide value never wraps. The order-dependent properties also assume that the order and the fraction settings change only while reset is held. The stimulus follows these rules: every configuration is applied with rst_ni low, the sweep picks the numerator and seed below each small denominator, and the wide-value runs use a full 32-bit denominator with the numerator and seed beneath it. The sync runs change only the request, tick and delay inputs while the block is running.

// File: rtl/fracn_sdm_pkg.sv
package fracn_sdm_pkg;

  localparam int unsigned SDM_MAX_ORDER = 4;

  function automatic int unsigned binom(int unsigned n, int unsigned k);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < k; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  // correction limits for a given cascade order
  function automatic int corr_max(int unsigned ord);
    return (ord == 0) ? 0 : (1 << (ord - 1));
  endfunction

  function automatic int corr_min(int unsigned ord);
    return (ord <= 1) ? 0 : -((1 << (ord - 1)) - 1);
  endfunction

endpackage

// File: rtl/sdm_acc_stage.sv
module sdm_acc_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] init_i,
  input  logic [W-1:0] add_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);

  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, add_i};
  assign carry_o = en_i && (sum >= {1'b0, den_i});
  assign res_o   = carry_o ? (sum[W-1:0] - den_i) : sum[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= init_i;
    else if (en_i)   acc_q <= res_o;
  end

  assert_residue_below_den_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < den_i)
    else $error("stage residue reached modulus");

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(acc_q))
    else $error("disabled stage changed state");

endmodule

// File: rtl/sdm_diff_net.sv
module sdm_diff_net #(
  parameter int unsigned MAX_ORDER = fracn_sdm_pkg::SDM_MAX_ORDER,
  parameter int unsigned CORR_W    = MAX_ORDER + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic [MAX_ORDER-1:0]     carry_i,
  output logic signed [CORR_W-1:0] corr_o
);

  typedef logic signed [CORR_W-1:0] term_t;

  logic [MAX_ORDER*CORR_W-1:0] terms;

  for (genvar k = 0; k < MAX_ORDER; k++) begin : g_ord
    logic [k:0] tap;
    term_t      term;

    assign tap[0] = carry_i[k];

    if (k > 0) begin : g_hist
      logic [k:1] past_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      past_q <= '0;
        else if (clear_i) past_q <= '0;
        else              past_q <= tap[k-1:0];
      end
      assign tap[k:1] = past_q;
    end

    // (1 - z^-1)^k applied to carry k+1
    always_comb begin
      term = '0;
      for (int j = 0; j <= k; j++) begin
        if (tap[j]) begin
          if (j % 2 == 1) term = term - term_t'(fracn_sdm_pkg::binom(k, j));
          else            term = term + term_t'(fracn_sdm_pkg::binom(k, j));
        end
      end
    end

    assign terms[k*CORR_W +: CORR_W] = term;
  end

  always_comb begin
    corr_o = '0;
    for (int k = 0; k < MAX_ORDER; k++) corr_o = corr_o + term_t'(terms[k*CORR_W +: CORR_W]);
  end

endmodule

// File: rtl/sdm_sync_delay.sv
module sdm_sync_delay #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic             fire_o
);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  // a new request outranks an expiring count
  assign fire_o = armed_q && (cnt_q == '0) && !req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (req_i) begin
      armed_q <= 1'b1;
      cnt_q   <= dly_i;
    end else if (fire_o) begin
      armed_q <= 1'b0;
    end else if (armed_q && tick_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_count_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !tick_i && !req_i) |=> $stable(cnt_q))
    else $error("delay counter moved without a tick");

  assert_fire_disarms_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !armed_q)
    else $error("counter still armed after re-seed");

  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (armed_q && cnt_q == $past(dly_i)))
    else $error("request did not restart the count");

endmodule

// File: rtl/fracn_sdm.sv
module fracn_sdm
  import fracn_sdm_pkg::*;
#(
  parameter int unsigned N_W       = 19,
  parameter int unsigned FRAC_W    = 32,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned ORD_W     = 3,
  parameter int unsigned MAX_ORDER = SDM_MAX_ORDER
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_W-1:0]    n_int_i,
  input  logic [FRAC_W-1:0] num_i,
  input  logic [FRAC_W-1:0] den_i,
  input  logic [FRAC_W-1:0] seed_i,
  input  logic [ORD_W-1:0]  order_i,
  input  logic              sm_tick_i,
  input  logic              sync_req_i,
  input  logic [CNT_W-1:0]  sync_dly_i,
  output logic [N_W:0]      div_o
);

  localparam int unsigned CORR_W = MAX_ORDER + 1;
  localparam logic [ORD_W-1:0] ORD_LIMIT = ORD_W'(MAX_ORDER);

  logic                          start_q;
  logic                          fire;
  logic                          reseed;
  logic                          order_ok;
  logic [MAX_ORDER-1:0]          stage_en;
  logic [MAX_ORDER-1:0]          carry;
  logic [MAX_ORDER:0][FRAC_W-1:0] chain;
  logic signed [CORR_W-1:0]      corr_d;
  logic signed [CORR_W-1:0]      corr_q;

  assign order_ok = (order_i <= ORD_LIMIT);
  assign reseed   = start_q | fire;
  assign chain[0] = num_i;

  for (genvar k = 0; k < MAX_ORDER; k++) begin : g_stage
    logic [FRAC_W-1:0] init;
    if (k == 0) begin : g_seed
      assign init = seed_i;
    end else begin : g_zero
      assign init = '0;
    end

    assign stage_en[k] = order_ok && (order_i > ORD_W'(k));

    sdm_acc_stage #(.W(FRAC_W)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (stage_en[k]),
      .load_i  (reseed),
      .init_i  (init),
      .add_i   (chain[k]),
      .den_i   (den_i),
      .res_o   (chain[k+1]),
      .carry_o (carry[k])
    );
  end

  sdm_diff_net #(.MAX_ORDER(MAX_ORDER), .CORR_W(CORR_W)) u_diff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (reseed),
    .carry_i (carry),
    .corr_o  (corr_d)
  );

  sdm_sync_delay #(.CNT_W(CNT_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (sync_req_i),
    .tick_i (sm_tick_i),
    .dly_i  (sync_dly_i),
    .fire_o (fire)
  );

  // first edge after reset acts as the seed load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b1;
    else         start_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     corr_q <= '0;
    else if (reseed) corr_q <= '0;
    else             corr_q <= corr_d;
  end

  assign div_o = {1'b0, n_int_i} + {{(N_W + 1 - CORR_W){corr_q[CORR_W-1]}}, corr_q};

  assert_corr_bounds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    order_ok |-> (corr_q <= corr_max(order_i) && corr_q >= corr_min(order_i)))
    else $error("correction outside order bound");

  assert_bypass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!order_ok || order_i == '0) |=> (div_o == {1'b0, n_int_i}))
    else $error("disabled modulator moved the divide value");

  assert_reseed_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reseed |=> (corr_q == '0))
    else $error("re-seed left a correction");

  assert_last_residue_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_en[MAX_ORDER-1] |-> (chain[MAX_ORDER] < den_i))
    else $error("last stage residue reached modulus");

endmodule

// File: tb/tb_fracn_sdm.sv
module tb_fracn_sdm;

  localparam int N_W    = 19;
  localparam int FRAC_W = 32;
  localparam int CNT_W  = 32;
  localparam int ORD_W  = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_ni;
  logic [N_W-1:0]    n_int;
  logic [FRAC_W-1:0] num, den, seed;
  logic [ORD_W-1:0]  order;
  logic              sm_tick, sync_req;
  logic [CNT_W-1:0]  sync_dly;
  logic [N_W:0]      div;

  fracn_sdm #(.N_W(N_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W), .ORD_W(ORD_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .n_int_i(n_int), .num_i(num), .den_i(den),
    .seed_i(seed), .order_i(order), .sm_tick_i(sm_tick), .sync_req_i(sync_req),
    .sync_dly_i(sync_dly), .div_o(div)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  longint acc_m[4];
  int h2;
  int h3[2];
  int h4[3];
  int corr_m;
  bit pend_start;
  longint ref_seq[20];
  longint post_seq[20];
  int post_cnt;

  function automatic void model_step(bit rs);
    int c[4];
    longint add, s;
    int eff;
    if (rs) begin
      acc_m[0] = longint'(seed);
      for (int k = 1; k < 4; k++) acc_m[k] = 0;
      h2 = 0; h3[0] = 0; h3[1] = 0; h4[0] = 0; h4[1] = 0; h4[2] = 0;
      corr_m = 0;
      return;
    end
    eff = (order <= 3'd4) ? int'(order) : 0;
    add = longint'(num);
    for (int k = 0; k < 4; k++) begin
      c[k] = 0;
      if (k < eff) begin
        s = acc_m[k] + add;
        if (s >= longint'(den)) begin c[k] = 1; s = s - longint'(den); end
        acc_m[k] = s;
        add = s;
      end
    end
    corr_m = c[0] + (c[1] - h2) + (c[2] - 2*h3[0] + h3[1])
           + (c[3] - 3*h4[0] + 3*h4[1] - h4[2]);
    h2 = c[1];
    h3[1] = h3[0]; h3[0] = c[2];
    h4[2] = h4[1]; h4[1] = h4[0]; h4[0] = c[3];
  endfunction

  function automatic longint exp_div();
    return longint'(n_int) + longint'(corr_m);
  endfunction

  task automatic check(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic configure(int nn, longint nm, longint dd, longint sd, int od);
    @(negedge clk);
    rst_ni = 1'b0;
    n_int = N_W'(nn); num = FRAC_W'(nm); den = FRAC_W'(dd); seed = FRAC_W'(sd);
    order = ORD_W'(od); sync_req = 1'b0; sm_tick = 1'b1; sync_dly = '0;
    corr_m = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    pend_start = 1'b1;
  endtask

  task automatic cycle(bit req, bit tk, bit rs, inout int mism, inout longint fa, inout longint fe);
    sync_req = req; sm_tick = tk;
    @(posedge clk);
    model_step(rs | pend_start);
    pend_start = 1'b0;
    @(negedge clk);
    if (longint'(div) != exp_div()) begin
      if (mism == 0) begin fa = longint'(div); fe = exp_div(); end
      mism++;
    end
  endtask

  task automatic run_plain(int n, string tag);
    int mism = 0;
    longint fa = 0, fe = 0;
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b1, 1'b0, mism, fa, fe);
    check(mism == 0, tag, fa, fe);
  endtask

  task automatic sync_run(int d, int tick_per, int restart_at, int d2, int total, int exp_cyc, string tag);
    int mism = 0;
    longint fa = 0, fe = 0;
    bit armed = 0;
    int left = 0;
    int got = -1;
    bit rq, tk, rs;
    sync_dly = CNT_W'(d);
    for (int cyc = 0; cyc < total; cyc++) begin
      rq = (cyc == 0) || (cyc == restart_at);
      if (cyc == restart_at) sync_dly = CNT_W'(d2);
      tk = (cyc % tick_per) == 0;
      rs = armed && (left == 0) && !rq;
      cycle(rq, tk, rs, mism, fa, fe);
      if (rs) begin got = cyc; post_cnt = 0; end
      if (got >= 0 && post_cnt < 20) begin post_seq[post_cnt] = longint'(div); post_cnt++; end
      if (rq) begin armed = 1; left = (cyc == 0) ? d : d2; end
      else if (rs) armed = 0;
      else if (armed && tk && left > 0) left--;
    end
    sync_req = 1'b0;
    check(mism == 0, {tag, " output sequence"}, fa, fe);
    check(got == exp_cyc, {tag, " re-seed edge"}, got, exp_cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int mism;
    longint fa, fe, sum;
    rst_ni = 1'b0; n_int = N_W'(1234); num = '0; den = FRAC_W'(1); seed = '0;
    order = 3'd2; sm_tick = 1'b0; sync_req = 1'b0; sync_dly = '0;
    pend_start = 1'b0; post_cnt = 0;
    repeat (3) @(negedge clk);

    // R2: divide value during reset
    check(div == 20'd1234, "R2 value in reset", longint'(div), 1234);

    // R2: seed loaded at first edge (hand values)
    configure(100, 1, 4, 3, 1);
    mism = 0; fa = 0; fe = 0;
    cycle(1'b0, 1'b1, 1'b0, mism, fa, fe);
    check(div == 20'd100, "R2 load edge", longint'(div), 100);
    cycle(1'b0, 1'b1, 1'b0, mism, fa, fe);
    check(div == 20'd101, "R2 seeded carry", longint'(div), 101);

    // R1 R4: sweep of every order over small moduli
    for (int od = 0; od < 8; od++) begin
      for (int d = 1; d < 10; d++) begin
        for (int nm = 0; nm < d; nm++) begin
          configure(500, nm, d, (nm * 3 + 1) % d, od);
          run_plain(2 * d + 6, $sformatf("%s order=%0d num=%0d den=%0d",
                    (od >= 1 && od <= 4) ? "R4" : "R1", od, nm, d));
        end
      end
    end

    // R5: order 1 average over DEN cycles
    configure(200, 3, 7, 5, 1);
    mism = 0; fa = 0; fe = 0;
    cycle(1'b0, 1'b1, 1'b0, mism, fa, fe);
    sum = 0;
    for (int i = 0; i < 7; i++) begin
      cycle(1'b0, 1'b1, 1'b0, mism, fa, fe);
      sum += longint'(div) - 200;
    end
    check(sum == 3, "R5 correction sum over DEN cycles", sum, 3);

    // R3 R6: full-width modulus
    configure(70000, 64'h1234_5678, 64'hFD51_DA80, 64'hABCD_EF01, 3);
    run_plain(300, "R3 wide order 3");
    configure(70000, 64'hFD51_DA7F, 64'hFD51_DA80, 64'hFD51_DA7F, 4);
    run_plain(200, "R3 R6 wide order 4 near-full numerator");

    // R7 R10 R9: delayed re-seed
    configure(300, 4, 11, 7, 2);
    run_plain(5, "R7 before request");
    sync_run(4, 3, -1, 0, 25, 13, "R7 sparse ticks");
    sync_run(0, 1, -1, 0, 6, 1, "R10 zero delay");
    sync_run(6, 1, 3, 2, 20, 6, "R9 restart");

    // R8: sequence after re-seed repeats the post-reset sequence
    configure(400, 5, 13, 9, 4);
    mism = 0; fa = 0; fe = 0;
    for (int i = 0; i < 20; i++) begin
      cycle(1'b0, 1'b1, 1'b0, mism, fa, fe);
      ref_seq[i] = longint'(div);
    end
    check(mism == 0, "R8 post-reset sequence", fa, fe);
    run_plain(7, "R8 free run");
    sync_run(2, 1, -1, 0, 24, 3, "R8 re-seed");
    mism = 0; fa = 0; fe = 0;
    for (int i = 0; i < 20; i++) begin
      if (post_seq[i] != ref_seq[i]) begin
        if (mism == 0) begin fa = post_seq[i]; fe = ref_seq[i]; end
        mism++;
      end
    end
    check(mism == 0 && post_cnt == 20, "R8 repeated sequence", fa, fe);

    // R7: no ticks, no re-seed
    sync_run(3, 1000, -1, 0, 30, -1, "R7 tick held low");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule